// File: doc/BRIEF.md
# Prescaled PWM Timer

A single-channel pulse-width modulator behind a two-word register interface. The input clock passes through a power-of-two prescaler. A 10-bit period counter advances on each prescaled tick. The output is high for the first `phase` ticks of every period and low for the rest. The divider exponent is written in two parts: an odd/even select bit and a 4-bit upper field, so that exponent = 2*field + select. Values above 24 are clamped to 24.

Software sets a staging bit before it rewrites the period, phase or divider, and clears the bit once all the new values are in place. While the timer runs, those values are held in shadow storage. They move to the live counter together, at a period boundary. While the timer is stopped, the live counter follows the shadows at once. A zero period or a zero phase is not allowed. A request to start under such a setting is refused, and a staged zero setting is never applied to a running timer.

Top module: `pwm_prescale_timer`

## Requirements
- R1: After reset the output is low and both registers read as zero.
- R2: The control word (address 0x0) keeps run at bit 0, staging at bit 11, odd/even select at bit 15 and the upper divider field at bits [19:16]. The count word (address 0x4) keeps the period at [25:16] and the phase at [9:0]. Written fields read back as written. Every other bit, bit 4 included, reads as zero and ignores writes.
- R3: A write that sets the run bit while the timer is stopped and the count word has a zero period or a zero phase leaves the run bit reading 0 and the output low.
- R4: With exponent e, period P and phase H < P, each period is high for H*2^e clocks and then low for (P-H)*2^e clocks.
- R5: When H >= P, the output stays high for the whole time the timer runs.
- R6: Writing the run bit as 0 drives the output low on the next clock and restarts the prescaler and the counter. The next start then begins with a full high phase.
- R7: Period, phase and divider values written while the timer is stopped apply from the first clock after the start.
- R8: While the staging bit is 1, writes to period, phase or divider do not change the running waveform. After the bit is cleared, all of the new values apply together from the next period boundary.
- R9: With the staging bit at 0, a count write during a running period applies only from the next period boundary.
- R10: A staged setting with a zero period or a zero phase is never applied while the timer runs, and the previous waveform continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address (0x0 control, 0x4 count) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach is a staged update that lands on a running timer. The new period, phase and divider must all switch at one boundary, and a half-applied mix must never appear. The bench starts the timer and stages a new count together with a changed divider. It measures whole high and low runs while the staging bit is held. It then clears the bit and measures the first full period after it. A separate case writes a zero phase into a running timer and confirms the old waveform continues.

// File: rtl/pwm_prescale_timer.sv
module pwm_prescale_timer #(
  parameter int ADDR_W  = 4,
  parameter int CNT_W   = 10,
  parameter int FLD_W   = 4,
  parameter int MAX_EXP = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_out
);
  localparam int EXP_W = FLD_W + 1;
  localparam int PRE_W = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(4);
  localparam int B_RUN  = 0;
  localparam int B_STG  = 11;
  localparam int B_ODD  = 15;
  localparam int B_FLD  = 16;
  localparam int B_PER  = 16;
  localparam int B_PH   = 0;

  logic             run_q, stg_q, odd_q, pend_q;
  logic [FLD_W-1:0] fld_q;
  logic [CNT_W-1:0] sh_per, sh_ph, act_per, act_ph, cnt_q;
  logic [EXP_W-1:0] act_exp, exp_req, exp_new;
  logic [PRE_W-1:0] pre_q, lowmask;
  logic             wr_ctrl, wr_count, sh_legal, tick, wrap, load;

  assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
  assign wr_count = bus_sel && bus_wr && (bus_addr == A_COUNT);
  assign sh_legal = (sh_per != '0) && (sh_ph != '0);
  assign exp_req  = {fld_q, odd_q};
  assign exp_new  = (exp_req > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : exp_req;
  assign lowmask  = ~({PRE_W{1'b1}} << act_exp);
  assign tick     = run_q && ((pre_q & lowmask) == lowmask);
  assign wrap     = tick && (cnt_q == act_per - CNT_W'(1));
  assign load     = !run_q || (pend_q && !stg_q && wrap && sh_legal);
  assign pwm_out  = run_q && (cnt_q < act_ph);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      stg_q <= 1'b0;
      odd_q <= 1'b0;
      fld_q <= '0;
    end else if (wr_ctrl) begin
      run_q <= bus_wdata[B_RUN] && (run_q || sh_legal);
      stg_q <= bus_wdata[B_STG];
      odd_q <= bus_wdata[B_ODD];
      fld_q <= bus_wdata[B_FLD +: FLD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_per <= '0;
      sh_ph  <= '0;
    end else if (wr_count) begin
      sh_per <= bus_wdata[B_PER +: CNT_W];
      sh_ph  <= bus_wdata[B_PH +: CNT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else if (wr_ctrl || wr_count) pend_q <= 1'b1;
    else if (load) pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_per <= '0;
      act_ph  <= '0;
      act_exp <= '0;
    end else if (load) begin
      act_per <= sh_per;
      act_ph  <= sh_ph;
      act_exp <= exp_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!run_q) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (tick) begin
      pre_q <= '0;
      cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (bus_addr == A_CTRL) begin
        bus_rdata[B_RUN] = run_q;
        bus_rdata[B_STG] = stg_q;
        bus_rdata[B_ODD] = odd_q;
        bus_rdata[B_FLD +: FLD_W] = fld_q;
      end else if (bus_addr == A_COUNT) begin
        bus_rdata[B_PER +: CNT_W] = sh_per;
        bus_rdata[B_PH +: CNT_W]  = sh_ph;
      end
    end
  end

  p_refuse_illegal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_RUN] && !run_q && !sh_legal) |=> !run_q);

  p_stop_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !bus_wdata[B_RUN]) |=> !pwm_out);

  p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < act_per));

  p_frozen_staged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && $past(stg_q)) |->
      ($stable(act_per) && $stable(act_ph) && $stable(act_exp)));

  p_live_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (act_per != '0 && act_ph != '0));
endmodule

// File: tb/pwm_prescale_timer_test.sv
module pwm_prescale_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [31:0] RUN = 32'h1, STG = 32'h800, ODD = 32'h8000;

  pwm_prescale_timer uut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  function automatic logic [31:0] cnt_word(input int p, input int h);
    return (32'(p) << 16) | 32'(h);
  endfunction

  function automatic logic [31:0] div_word(input int e);
    return ((e & 1) ? ODD : 32'h0) | (32'(e >> 1) << 16);
  endfunction

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (pwm_out == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    int k = 0;
    while (pwm_out == 1 && k < 5000) begin k++; @(negedge clk); end
    while (pwm_out == 0 && k < 5000) begin k++; @(negedge clk); end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int h, l, n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    chk(pwm_out == 0, "R1 out", int'(pwm_out), 0);
    rd(4'h0, d); chk(d == 0, "R1 ctrl", int'(d), 0);
    rd(4'h4, d); chk(d == 0, "R1 count", int'(d), 0);
    // R2
    wr(4'h0, 32'hFFFF_FFFE);
    rd(4'h0, d); chk(d == 32'h000F_8800, "R2 ctrl", int'(d), 32'h000F_8800);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk(d == 32'h03FF_03FF, "R2 count", int'(d), 32'h03FF_03FF);
    wr(4'h0, 32'h0000_8810);
    rd(4'h0, d); chk(d == 32'h0000_8800, "R2 bit4", int'(d), 32'h0000_8800);
    wr(4'h0, 0);
    // R3
    wr(4'h4, cnt_word(0, 5)); wr(4'h0, RUN);
    rd(4'h0, d); chk(d[0] == 0, "R3 zero period", int'(d[0]), 0);
    n = 0; repeat (20) begin @(negedge clk); n += pwm_out; end
    chk(n == 0, "R3 out low", n, 0);
    wr(4'h4, cnt_word(5, 0)); wr(4'h0, RUN);
    rd(4'h0, d); chk(d[0] == 0, "R3 zero phase", int'(d[0]), 0);
    chk(pwm_out == 0, "R3 out low", int'(pwm_out), 0);
    // R4 R5 R7 sweep
    for (int e = 0; e < 4; e++) begin
      for (int pi = 0; pi < 5; pi++) begin
        int p;
        p = (pi == 0) ? 1 : (pi == 1) ? 2 : (pi == 2) ? 3 : (pi == 3) ? 5 : 7;
        for (int ph = 1; ph <= p + 1; ph++) begin
          wr(4'h0, div_word(e));
          wr(4'h4, cnt_word(p, ph));
          wr(4'h0, div_word(e) | RUN);
          if (ph < p) begin
            run_len(1, h); chk(h == ph << e, "R4 R7 high", h, ph << e);
            run_len(0, l); chk(l == (p - ph) << e, "R4 low", l, (p - ph) << e);
          end else begin
            n = 0;
            for (int k = 0; k < (3 * p << e) + 2; k++) begin n += pwm_out; @(negedge clk); end
            chk(n == (3 * p << e) + 2, "R5 always high", n, (3 * p << e) + 2);
          end
          wr(4'h0, div_word(e));
        end
      end
    end
    // R6
    wr(4'h4, cnt_word(6, 4)); wr(4'h0, ODD | RUN);
    wait_rise(); repeat (3) @(negedge clk);
    wr(4'h0, ODD);
    chk(pwm_out == 0, "R6 stop low", int'(pwm_out), 0);
    n = 0; repeat (5) begin @(negedge clk); n += pwm_out; end
    chk(n == 0, "R6 stays low", n, 0);
    wr(4'h0, ODD | RUN);
    run_len(1, h); chk(h == 8, "R6 fresh high", h, 8);
    run_len(0, l); chk(l == 4, "R6 fresh low", l, 4);
    wr(4'h0, 0);
    // R8
    wr(4'h4, cnt_word(4, 2)); wr(4'h0, RUN);
    wr(4'h0, RUN | STG);
    wr(4'h4, cnt_word(6, 3));
    wr(4'h0, RUN | STG | ODD);
    for (int k = 0; k < 2; k++) begin
      wait_rise();
      run_len(1, h); chk(h == 2, "R8 held high", h, 2);
      run_len(0, l); chk(l == 2, "R8 held low", l, 2);
    end
    wr(4'h0, RUN | ODD);
    wait_rise();
    run_len(1, h); chk(h == 6, "R8 new high", h, 6);
    run_len(0, l); chk(l == 6, "R8 new low", l, 6);
    wr(4'h0, 0);
    // R9
    wr(4'h4, cnt_word(4, 1)); wr(4'h0, RUN);
    wait_rise();
    wr(4'h4, cnt_word(8, 6));
    run_len(1, n); chk(n <= 1, "R9 not mid-period", n, 1);
    wait_rise();
    run_len(1, h); chk(h == 6, "R9 next high", h, 6);
    run_len(0, l); chk(l == 2, "R9 next low", l, 2);
    // R10
    wr(4'h4, cnt_word(5, 0));
    for (int k = 0; k < 2; k++) begin
      wait_rise();
      run_len(1, h); chk(h == 6, "R10 old high", h, 6);
      run_len(0, l); chk(l == 2, "R10 old low", l, 2);
    end
    wr(4'h4, cnt_word(3, 1));
    wait_rise();
    run_len(1, h); chk(h == 1, "R10 fixed high", h, 1);
    run_len(0, l); chk(l == 2, "R10 fixed low", l, 2);
    wr(4'h0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule